// File: doc/BRIEF.md
# Dual-Region Key Unlock Sequencer

This block keeps two write-protected memory regions locked until software proves intent. The program region covers byte addresses 0x8000 and up, and the data region covers everything below 0x8000. Each region has its own key register. Software opens a region by writing two fixed key bytes to that key register, back to back and in the correct order. A wrong byte at either step sends that region into a failed state. The failed state ignores all further keys until reset.

The unlock state of both regions shows up as two bits of a shared status register. When software writes that register with a region's bit cleared, the region locks again, and any half-entered key sequence for it is dropped. Writing a 1 to a status bit has no effect. A region can only be opened through its keys.

Access is over a byte-wide register bus. Read data is registered, so a value appears one cycle after the read strobe. Per-region unlocked outputs go to the memory write path. A two-bit state per region is exposed for debug.

Top module: `keyguard_top`

## Requirements
- R1: After reset, both regions are locked: state code 0, unlocked outputs low, and status reads 0x00. Reset also clears a failed state.
- R2: Writing 0x56 and then 0xAE to the program key register (address 1) unlocks the program region. After the first byte the state is 1. After the second byte the state is 2 and progUnlocked is high, both visible the cycle after the write.
- R3: Writing 0xAE and then 0x56 to the data key register (address 2) unlocks the data region. Neither region's keys change the other region's state.
- R4: If the first key byte written to a locked region is wrong, that region goes to state 3 (failed) and stays locked.
- R5: If the byte written after a correct first key is not the second key, the region goes to state 3 and stays locked.
- R6: A failed region ignores every later key write, including a correct sequence. It also ignores status writes, and leaves state 3 only through reset.
- R7: Reads of either key register return 0x00.
- R8: Status (address 0) bit 1 reads 1 while the program region is unlocked, and bit 3 reads 1 while the data region is unlocked. All other bits read 0. Writing 1 to either bit does not unlock anything.
- R9: A status write with bit 1 clear returns a non-failed program region to state 0. Bit 3 does the same for the data region. Any first-key progress is discarded, so a following second key counts as a wrong first key.
- R10: Key writes to a region that is already unlocked are ignored.
- R11: regRdata holds the value addressed by a read strobe in the cycle after the strobe, and reads 0x00 in the cycle after any cycle with no strobe. A status read and a status write in the same cycle return the status as it stood before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register address: 0 status, 1 program key, 2 data key |
| regWdata | input | 8 | Write data |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regRdata | output | 8 | Registered read data |
| progUnlocked | output | 1 | Program region writable |
| dataUnlocked | output | 1 | Data region writable |
| progState | output | 2 | Program channel state: 0 locked, 1 first key seen, 2 unlocked, 3 failed |
| dataState | output | 2 | Data channel state, same encoding |

## Verification
A status read and a status relock can land in the same cycle, because the bus allows both strobes at once. The bench asserts both strobes together at address 0 with data 0x00 while the program region is open. It then checks two things. The returned byte must still show bit 1 set, taken from the state before the write. In the same following cycle, the program state must already read locked. A follow-up read then confirms that the status reads 0x00.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;

  typedef enum logic [1:0] {
    CH_LOCKED = 2'd0,
    CH_FIRST  = 2'd1,
    CH_OPEN   = 2'd2,
    CH_FAILED = 2'd3
  } chanState_e;

  typedef struct packed {
    logic progKeyWr;
    logic dataKeyWr;
    logic statusWr;
    logic statusRd;
    logic anyRd;
  } busStrobe_t;

endpackage

// File: rtl/keyguard_ctrl.sv
module keyguard_ctrl
  import keyguard_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int ADDR_STATUS = 0,
  parameter int ADDR_PKEY   = 1,
  parameter int ADDR_DKEY   = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  output busStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(ADDR_STATUS);
  localparam logic [ADDR_W-1:0] A_PK = ADDR_W'(ADDR_PKEY);
  localparam logic [ADDR_W-1:0] A_DK = ADDR_W'(ADDR_DKEY);

  always_comb begin
    strobe           = '0;
    strobe.progKeyWr = regWr && (regAddr == A_PK);
    strobe.dataKeyWr = regWr && (regAddr == A_DK);
    strobe.statusWr  = regWr && (regAddr == A_ST);
    strobe.statusRd  = regRd && (regAddr == A_ST);
    strobe.anyRd     = regRd;
  end

endmodule

// File: rtl/keyguard_chan.sv
module keyguard_chan
  import keyguard_pkg::*;
#(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h56,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'hAE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyWr,
  input  logic [DATA_W-1:0] keyData,
  input  logic              relock,
  output chanState_e        state,
  output logic              unlocked
);

  chanState_e stNext;

  always_comb begin
    stNext = state;
    if (relock && state != CH_FAILED) begin
      stNext = CH_LOCKED;
    end else if (keyWr) begin
      case (state)
        CH_LOCKED: stNext = (keyData == KEY_FIRST)  ? CH_FIRST : CH_FAILED;
        CH_FIRST:  stNext = (keyData == KEY_SECOND) ? CH_OPEN  : CH_FAILED;
        default:   stNext = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= CH_LOCKED;
    else       state <= stNext;
  end

  assign unlocked = (state == CH_OPEN);

endmodule

// File: rtl/keyguard_dp.sv
module keyguard_dp
  import keyguard_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] KEY_P1   = 8'h56,
  parameter logic [DATA_W-1:0] KEY_P2   = 8'hAE,
  parameter logic [DATA_W-1:0] KEY_D1   = 8'hAE,
  parameter logic [DATA_W-1:0] KEY_D2   = 8'h56,
  parameter int                PROG_BIT = 1,
  parameter int                DATA_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output chanState_e        progState,
  output chanState_e        dataState,
  output logic              progUnlocked,
  output logic              dataUnlocked
);

  localparam int NCH = 2;

  chanState_e        chState [NCH];
  logic [NCH-1:0]    chOpen;
  logic [DATA_W-1:0] statusImage;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
    localparam logic [DATA_W-1:0] KA  = (gi == 0) ? KEY_P1 : KEY_D1;
    localparam logic [DATA_W-1:0] KB  = (gi == 0) ? KEY_P2 : KEY_D2;
    localparam int                BIT = (gi == 0) ? PROG_BIT : DATA_BIT;
    logic keyWr;
    logic relock;
    assign keyWr  = (gi == 0) ? strobe.progKeyWr : strobe.dataKeyWr;
    assign relock = strobe.statusWr && !regWdata[BIT];
    keyguard_chan #(
      .DATA_W(DATA_W), .KEY_FIRST(KA), .KEY_SECOND(KB)
    ) u_chan (
      .clk(clk), .rstN(rstN), .keyWr(keyWr), .keyData(regWdata),
      .relock(relock), .state(chState[gi]), .unlocked(chOpen[gi])
    );
  end

  always_comb begin
    statusImage           = '0;
    statusImage[PROG_BIT] = chOpen[0];
    statusImage[DATA_BIT] = chOpen[1];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                regRdata <= '0;
    else if (strobe.statusRd) regRdata <= statusImage;
    else                      regRdata <= '0;
  end

  assign progState    = chState[0];
  assign dataState    = chState[1];
  assign progUnlocked = chOpen[0];
  assign dataUnlocked = chOpen[1];

endmodule

// File: rtl/keyguard_top.sv
module keyguard_top
  import keyguard_pkg::*;
#(
  parameter int         ADDR_W      = 2,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] KEY_P1      = 8'h56,
  parameter logic [7:0] KEY_P2      = 8'hAE,
  parameter logic [7:0] KEY_D1      = 8'hAE,
  parameter logic [7:0] KEY_D2      = 8'h56,
  parameter int         ADDR_STATUS = 0,
  parameter int         ADDR_PKEY   = 1,
  parameter int         ADDR_DKEY   = 2,
  parameter int         PROG_BIT    = 1,
  parameter int         DATA_BIT    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWr,
  input  logic              regRd,
  output logic [DATA_W-1:0] regRdata,
  output logic              progUnlocked,
  output logic              dataUnlocked,
  output logic [1:0]        progState,
  output logic [1:0]        dataState
);

  busStrobe_t strobe;
  chanState_e pSt, dSt;

  keyguard_ctrl #(
    .ADDR_W(ADDR_W), .ADDR_STATUS(ADDR_STATUS),
    .ADDR_PKEY(ADDR_PKEY), .ADDR_DKEY(ADDR_DKEY)
  ) u_ctrl (
    .regAddr(regAddr), .regWr(regWr), .regRd(regRd), .strobe(strobe)
  );

  keyguard_dp #(
    .DATA_W(DATA_W),
    .KEY_P1(DATA_W'(KEY_P1)), .KEY_P2(DATA_W'(KEY_P2)),
    .KEY_D1(DATA_W'(KEY_D1)), .KEY_D2(DATA_W'(KEY_D2)),
    .PROG_BIT(PROG_BIT), .DATA_BIT(DATA_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWdata(regWdata),
    .regRdata(regRdata), .progState(pSt), .dataState(dSt),
    .progUnlocked(progUnlocked), .dataUnlocked(dataUnlocked)
  );

  assign progState = pSt;
  assign dataState = dSt;

endmodule

// File: rtl/keyguard_chk.sv
module keyguard_chk #(
  parameter int         ADDR_W      = 2,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] KEY_P1      = 8'h56,
  parameter int         ADDR_PKEY   = 1,
  parameter int         ADDR_DKEY   = 2,
  parameter int         ADDR_STATUS = 0,
  parameter int         PROG_BIT    = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              regWr,
  input logic              regRd,
  input logic [DATA_W-1:0] regRdata,
  input logic              progUnlocked,
  input logic [1:0]        progState,
  input logic [1:0]        dataState
);

  // R6: failure is sticky until reset
  a_r6_prog_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    progState == 2'd3 |=> progState == 2'd3);
  a_r6_data_fail_sticky: assert property (@(posedge clk) disable iff (!rstN)
    dataState == 2'd3 |=> dataState == 2'd3);

  // R7: key registers read as zero
  a_r7_key_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && (regAddr == ADDR_W'(ADDR_PKEY) || regAddr == ADDR_W'(ADDR_DKEY)))
      |=> regRdata == '0);

  // R2: program region only opens on a program key write
  a_r2_open_by_key: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progUnlocked) |-> $past(regWr && regAddr == ADDR_W'(ADDR_PKEY)));

  // R4: wrong first key fails the program channel
  a_r4_bad_first: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_W'(ADDR_PKEY) && progState == 2'd0 &&
     regWdata != DATA_W'(KEY_P1)) |=> progState == 2'd3);

  // R9: clearing the status bit relocks a non-failed channel
  a_r9_relock: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_W'(ADDR_STATUS) && !regWdata[PROG_BIT] &&
     progState != 2'd3) |=> progState == 2'd0);

endmodule

bind keyguard_top keyguard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_P1(KEY_P1),
  .ADDR_PKEY(ADDR_PKEY), .ADDR_DKEY(ADDR_DKEY),
  .ADDR_STATUS(ADDR_STATUS), .PROG_BIT(PROG_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
  .regWr(regWr), .regRd(regRd), .regRdata(regRdata),
  .progUnlocked(progUnlocked), .progState(progState), .dataState(dataState)
);

// File: tb/keyguard_top_bench.sv
module keyguard_top_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] regAddr;
  logic [7:0] regWdata;
  logic       regWr, regRd;
  logic [7:0] regRdata;
  logic       progUnlocked, dataUnlocked;
  logic [1:0] progState, dataState;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  keyguard_top u_keyguard_top (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWr(regWr), .regRd(regRd), .regRdata(regRdata),
    .progUnlocked(progUnlocked), .dataUnlocked(dataUnlocked),
    .progState(progState), .dataState(dataState)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWr = 1'b0; regRd = 1'b0; regAddr = '0; regWdata = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    @(negedge clk);
    v = regRdata;
    regRd = 1'b0;
  endtask

  task automatic tResetState();
    logic [7:0] v;
    doReset();
    check("R1 progState", progState, 0);
    check("R1 dataState", dataState, 0);
    check("R1 unlocked outputs", {progUnlocked, dataUnlocked}, 0);
    rdReg(2'd0, v);
    check("R1 status after reset", v, 8'h00);
  endtask

  task automatic tProgUnlock();
    logic [7:0] v;
    doReset();
    wrReg(2'd1, 8'h56);
    check("R2 first key state", progState, 1);
    check("R2 not yet unlocked", progUnlocked, 0);
    wrReg(2'd1, 8'hAE);
    check("R2 unlocked state", progState, 2);
    check("R2 progUnlocked", progUnlocked, 1);
    check("R3 data untouched", dataState, 0);
    rdReg(2'd0, v);
    check("R8 status prog bit", v, 8'h02);
    rdReg(2'd1, v);
    check("R7 prog key reads zero", v, 8'h00);
    wrReg(2'd1, 8'h00);
    check("R10 key ignored while open", progState, 2);
    wrReg(2'd1, 8'h56);
    check("R10 first key ignored while open", progState, 2);
  endtask

  task automatic tSameCycle();
    logic [7:0] v;
    @(negedge clk);
    regAddr = 2'd0; regWdata = 8'h00; regWr = 1'b1; regRd = 1'b1;
    @(negedge clk);
    check("R11 read shows pre-write status", regRdata, 8'h02);
    check("R9 relocked same cycle", progState, 0);
    regWr = 1'b0; regRd = 1'b0;
    @(negedge clk);
    check("R11 idle read data zero", regRdata, 8'h00);
    rdReg(2'd0, v);
    check("R9 status after relock", v, 8'h00);
  endtask

  task automatic tDataUnlock();
    logic [7:0] v;
    doReset();
    wrReg(2'd2, 8'hAE);
    check("R3 data first key", dataState, 1);
    check("R3 prog untouched", progState, 0);
    wrReg(2'd2, 8'h56);
    check("R3 dataUnlocked", dataUnlocked, 1);
    wrReg(2'd0, 8'hFF);
    check("R8 write ones cannot open prog", progUnlocked, 0);
    check("R8 write ones keeps data open", dataState, 2);
    rdReg(2'd0, v);
    check("R8 status data bit", v, 8'h08);
    rdReg(2'd2, v);
    check("R7 data key reads zero", v, 8'h00);
  endtask

  task automatic tPartialDiscard();
    doReset();
    wrReg(2'd1, 8'h56);
    check("R9 partial progress", progState, 1);
    wrReg(2'd0, 8'h08);
    check("R9 partial discarded", progState, 0);
    wrReg(2'd1, 8'hAE);
    check("R9 lone second key fails", progState, 3);
  endtask

  task automatic tFailFirst();
    doReset();
    wrReg(2'd1, 8'h12);
    check("R4 wrong first key", progState, 3);
    check("R4 stays locked", progUnlocked, 0);
    wrReg(2'd1, 8'h56);
    wrReg(2'd1, 8'hAE);
    check("R6 correct keys ignored", progState, 3);
    wrReg(2'd0, 8'h00);
    check("R6 status write ignored", progState, 3);
    wrReg(2'd2, 8'hAE);
    wrReg(2'd2, 8'h56);
    check("R3 data independent of failed prog", dataUnlocked, 1);
  endtask

  task automatic tFailSecond();
    doReset();
    wrReg(2'd2, 8'hAE);
    wrReg(2'd2, 8'h11);
    check("R5 wrong second key", dataState, 3);
    check("R5 stays locked", dataUnlocked, 0);
    doReset();
    check("R1 reset clears failure", dataState, 0);
  endtask

  initial begin
    #400000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; regWr = 1'b0; regRd = 1'b0; regAddr = '0; regWdata = '0;
    tResetState();
    tProgUnlock();
    tSameCycle();
    tDataUnlock();
    tPartialDiscard();
    tFailFirst();
    tFailSecond();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule